// File: doc/BRIEF.md
# Shared-Unit Slot Scheduler for a Four-Unit Processing Group

This block models one processing group of four functional units. Each unit carries its own integer ALU. The group holds only one multiplier and one memory port, and all four units share them. Every cycle, each unit may present one operation. ALU work is done inside that unit. The shared multiplier and memory port go to one unit at a time, chosen by a static, rotating time slot. No arbitration logic decides ownership at run time.

A free-running phase counter advances once per running cycle. Each unit owns the shared resources in the cycle whose phase matches its configured slot number. When two logical lanes are mapped onto the group one cycle apart, they never reach the multiplier together. A request made outside the owner's slot is dropped and flagged as a schedule violation.

Operands reach the units through a crossbar. Each operand slot takes either an external value or the registered ALU result of any unit, which serves as a bypass. The selects for the crossbar and the slot numbers are loaded only while the group is stopped.

Top module: `pe_group_sched`

## Requirements
- R1: While reset is asserted, all of these outputs read zero: every ALU valid and result, multiplier valid, memory valid and every violation flag.
- R2: Operation codes are 3 bits per unit, held in op_code[3i+2:3i]. The codes are 0 none, 1 add, 2 subtract (A-B), 3 and, 4 xor, 5 multiply, 6 load and 7 store. For codes 1 to 4, alu_vld[i] and alu_res[16i+15:16i] show the 16-bit result one cycle later. For any other code, alu_vld[i] stays low and the result is held.
- R3: There are eight operand slots. Slot 2i is operand A of unit i and slot 2i+1 is operand B. Slot s uses the 3-bit select cfg_xbar[3s+2:3s]. Select 0 takes ext_opnd[16s+15:16s]. Select k from 1 to 4 takes the registered ALU result of unit k-1. Selects 5 to 7 give zero.
- R4: cfg_xbar and cfg_phase are captured only on a cycle where cfg_load is high and run is low. A load attempted while run is high has no effect.
- R5: The phase is 0 on the first running cycle. It then counts 0,1,2,3 and wraps on each running cycle, and it restarts at 0 whenever run is low. Unit i owns the shared slot when the phase equals cfg_phase[2i+1:2i]. If several units match, the lowest-numbered unit owns the slot.
- R6: A multiply from the owner gives mul_vld two cycles later. mul_res then holds the low 16 bits of A*B, and mul_tag holds the index of the issuing unit.
- R7: A load or store from the owner gives mem_vld one cycle later. At the same time mem_we is 1 for a store, mem_addr holds A, mem_wdata holds B and mem_tag holds the unit index.
- R8: A multiply, load or store from a unit that does not own the slot in a running cycle is dropped. It raises viol[i] for one cycle, one cycle later, and produces no multiplier or memory output.
- R9: While run is low, operations are ignored. No ALU valid, memory valid, multiplier issue or violation follows, and ALU results keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Group executing; low stops and restarts the phase |
| cfg_load | input | 1 | Capture configuration (honoured only while stopped) |
| cfg_xbar | input | 24 | Eight 3-bit operand-slot selects |
| cfg_phase | input | 8 | Four 2-bit slot numbers, one per unit |
| op_code | input | 12 | Four 3-bit operation codes |
| ext_opnd | input | 128 | Eight 16-bit external operands |
| alu_vld | output | 4 | Per-unit ALU result valid |
| alu_res | output | 64 | Per-unit registered ALU results |
| mul_vld | output | 1 | Multiplier result valid |
| mul_res | output | 16 | Low half of product |
| mul_tag | output | 2 | Unit that issued the multiply |
| mem_vld | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a store |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Store data |
| mem_tag | output | 2 | Unit that issued the memory access |
| viol | output | 4 | Per-unit schedule violation pulse |

## Verification
The bench has all four units ask for the multiplier every cycle through a full rotation of the phase. A design with the wrong phase origin or wrap would issue the wrong unit's product or tag, and would flag the wrong set of violators. A second sweep gives two units the same slot number and leaves one phase with no owner. A design that arbitrated dynamically, or that let two units issue at once, would then show a wrong tag or a missing violation. The bypass test changes the crossbar selects while the group is running. A design that did not freeze its configuration would switch operands in the middle of the run. The stopped cycles check that a design ignoring run would update results or raise flags.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_AND = 3'd3,
    OP_XOR = 3'd4,
    OP_MUL = 3'd5,
    OP_LD  = 3'd6,
    OP_ST  = 3'd7
  } op_e;

  function automatic logic is_shared(input logic [2:0] op);
    return (op == OP_MUL) || (op == OP_LD) || (op == OP_ST);
  endfunction
endpackage

// File: rtl/pe_xbar.sv
module pe_xbar #(
  parameter int NFU  = 4,
  parameter int W    = 16,
  parameter int SELW = 3
) (
  input  logic [2*NFU*SELW-1:0] sel,
  input  logic [2*NFU*W-1:0]    ext,
  input  logic [NFU*W-1:0]      fu_res,
  output logic [2*NFU*W-1:0]    opnd
);
  localparam int NSLOT = 2 * NFU;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [SELW-1:0] s_sel;
    logic [W-1:0]    s_val;
    assign s_sel = sel[s*SELW +: SELW];
    always_comb begin
      s_val = '0;
      if (s_sel == '0) s_val = ext[s*W +: W];
      for (int k = 0; k < NFU; k++) begin
        if (s_sel == SELW'(k + 1)) s_val = fu_res[k*W +: W];
      end
    end
    assign opnd[s*W +: W] = s_val;
  end
endmodule

// File: rtl/pe_alu.sv
module pe_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         vld,
  output logic [W-1:0] res
);
  import pe_pkg::*;

  logic         vld_d;
  logic [W-1:0] res_d;

  always_comb begin
    vld_d = 1'b0;
    res_d = '0;
    if (run) begin
      unique case (op)
        OP_ADD:  begin vld_d = 1'b1; res_d = a + b; end
        OP_SUB:  begin vld_d = 1'b1; res_d = a - b; end
        OP_AND:  begin vld_d = 1'b1; res_d = a & b; end
        OP_XOR:  begin vld_d = 1'b1; res_d = a ^ b; end
        default: begin vld_d = 1'b0; res_d = '0;    end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      res <= '0;
    end else begin
      vld <= vld_d;
      if (vld_d) res <= res_d;
    end
  end

  AST_ALU_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !vld); // R9
endmodule

// File: rtl/pe_shared_slot.sv
module pe_shared_slot #(
  parameter int NFU = 4,
  parameter int W   = 16,
  parameter int PHW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [NFU*3-1:0]   op_code,
  input  logic [2*NFU*W-1:0] opnd,
  input  logic [NFU*PHW-1:0] slot_cfg,
  output logic               mul_vld,
  output logic [W-1:0]       mul_res,
  output logic [PHW-1:0]     mul_tag,
  output logic               mem_vld,
  output logic               mem_we,
  output logic [W-1:0]       mem_addr,
  output logic [W-1:0]       mem_wdata,
  output logic [PHW-1:0]     mem_tag,
  output logic [NFU-1:0]     viol
);
  import pe_pkg::*;

  logic [PHW-1:0] phase_q, phase_d;
  logic [NFU-1:0] req, issue;
  logic           found;
  logic [PHW-1:0] idx;
  logic [2:0]     iss_op;
  logic [W-1:0]   iss_a, iss_b, prod_lo;
  logic           s1_vld_d, mem_vld_d;
  logic           s1_vld;
  logic [W-1:0]   s1_prod;
  logic [PHW-1:0] s1_tag;

  always_comb begin
    phase_d = phase_q;
    if (!run)                           phase_d = '0;
    else if (phase_q == PHW'(NFU - 1))  phase_d = '0;
    else                                phase_d = phase_q + 1'b1;
  end

  always_comb begin
    found  = 1'b0;
    idx    = '0;
    iss_op = OP_NOP;
    iss_a  = '0;
    iss_b  = '0;
    issue  = '0;
    for (int i = 0; i < NFU; i++) begin
      req[i] = run && is_shared(op_code[3*i +: 3]);
      if (req[i] && !found && (slot_cfg[i*PHW +: PHW] == phase_q)) begin
        found    = 1'b1;
        issue[i] = 1'b1;
        idx      = PHW'(i);
        iss_op   = op_code[3*i +: 3];
        iss_a    = opnd[(2*i)*W +: W];
        iss_b    = opnd[(2*i+1)*W +: W];
      end
    end
  end

  assign prod_lo   = iss_a * iss_b;
  assign s1_vld_d  = found && (iss_op == OP_MUL);
  assign mem_vld_d = found && (iss_op != OP_MUL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= '0;
      s1_vld    <= 1'b0;
      s1_prod   <= '0;
      s1_tag    <= '0;
      mul_vld   <= 1'b0;
      mul_res   <= '0;
      mul_tag   <= '0;
      mem_vld   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_tag   <= '0;
      viol      <= '0;
    end else begin
      phase_q <= phase_d;
      s1_vld  <= s1_vld_d;
      if (s1_vld_d) begin
        s1_prod <= prod_lo;
        s1_tag  <= idx;
      end
      mul_vld <= s1_vld;
      if (s1_vld) begin
        mul_res <= s1_prod;
        mul_tag <= s1_tag;
      end
      mem_vld <= mem_vld_d;
      if (mem_vld_d) begin
        mem_we    <= (iss_op == OP_ST);
        mem_addr  <= iss_a;
        mem_wdata <= iss_b;
        mem_tag   <= idx;
      end
      viol <= req & ~issue;
    end
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (phase_q == '0)); // R5
  AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    mul_vld |-> $past(run, 2)); // R6
  AST_OWNER_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vld |-> !viol[mem_tag]); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (viol == '0 && !mem_vld)); // R9
endmodule

// File: rtl/pe_group_sched.sv
module pe_group_sched (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cfg_load,
  input  logic [23:0]  cfg_xbar,
  input  logic [7:0]   cfg_phase,
  input  logic [11:0]  op_code,
  input  logic [127:0] ext_opnd,
  output logic [3:0]   alu_vld,
  output logic [63:0]  alu_res,
  output logic         mul_vld,
  output logic [15:0]  mul_res,
  output logic [1:0]   mul_tag,
  output logic         mem_vld,
  output logic         mem_we,
  output logic [15:0]  mem_addr,
  output logic [15:0]  mem_wdata,
  output logic [1:0]   mem_tag,
  output logic [3:0]   viol
);
  localparam int NFU  = 4;
  localparam int W    = 16;
  localparam int PHW  = $clog2(NFU);
  localparam int SELW = $clog2(NFU + 2);

  logic [2*NFU*SELW-1:0] xbar_q;
  logic [NFU*PHW-1:0]    slot_q;
  logic                  cfg_en;
  logic [2*NFU*W-1:0]    opnd;

  assign cfg_en = cfg_load && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xbar_q <= '0;
      slot_q <= '0;
    end else if (cfg_en) begin
      xbar_q <= cfg_xbar;
      slot_q <= cfg_phase;
    end
  end

  pe_xbar #(.NFU(NFU), .W(W), .SELW(SELW)) u_xbar (
    .sel    (xbar_q),
    .ext    (ext_opnd),
    .fu_res (alu_res),
    .opnd   (opnd)
  );

  for (genvar i = 0; i < NFU; i++) begin : g_fu
    pe_alu #(.W(W)) u_alu (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .op    (op_code[3*i +: 3]),
      .a     (opnd[(2*i)*W +: W]),
      .b     (opnd[(2*i+1)*W +: W]),
      .vld   (alu_vld[i]),
      .res   (alu_res[i*W +: W])
    );
  end

  pe_shared_slot #(.NFU(NFU), .W(W), .PHW(PHW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .op_code   (op_code),
    .opnd      (opnd),
    .slot_cfg  (slot_q),
    .mul_vld   (mul_vld),
    .mul_res   (mul_res),
    .mul_tag   (mul_tag),
    .mem_vld   (mem_vld),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_tag   (mem_tag),
    .viol      (viol)
  );

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(xbar_q) && $stable(slot_q))); // R4
endmodule

// File: tb/tb_pe_group_sched.sv
module tb_pe_group_sched;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         run;
  logic         cfg_load;
  logic [23:0]  cfg_xbar;
  logic [7:0]   cfg_phase;
  logic [11:0]  op_code;
  logic [127:0] ext_opnd;
  logic [3:0]   alu_vld;
  logic [63:0]  alu_res;
  logic         mul_vld;
  logic [15:0]  mul_res;
  logic [1:0]   mul_tag;
  logic         mem_vld;
  logic         mem_we;
  logic [15:0]  mem_addr;
  logic [15:0]  mem_wdata;
  logic [1:0]   mem_tag;
  logic [3:0]   viol;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] m_res [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pe_group_sched dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_op(input int i, input logic [2:0] code, input logic [15:0] a, input logic [15:0] b);
    op_code[3*i +: 3]        = code;
    ext_opnd[32*i +: 16]     = a;
    ext_opnd[32*i + 16 +: 16] = b;
  endtask

  function automatic logic [15:0] alu_f(input int op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      1: return a + b;
      2: return a - b;
      3: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] av [4];
    logic [15:0] bv [4];
    logic [15:0] mexp [8];
    int          own;
    rst_n = 1'b0; run = 1'b0; cfg_load = 1'b0; cfg_xbar = '0; cfg_phase = '0;
    op_code = '0; ext_opnd = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 alu_vld", 32'(alu_vld), 0);
    check("R1 alu_res", alu_res[31:0] | alu_res[63:32], 0);
    check("R1 mul/mem valid", {mul_vld, mem_vld}, 0);
    check("R1 viol", 32'(viol), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) m_res[i] = '0;

    // configuration: external operands, unit i owns phase i
    cfg_load = 1'b1; cfg_xbar = '0; cfg_phase = 8'hE4;
    @(negedge clk);
    cfg_load = 1'b0;

    // R2 ALU sweep over all four codes and several patterns
    run = 1'b1;
    for (int op = 1; op <= 4; op++) begin
      for (int v = 0; v < 6; v++) begin
        for (int i = 0; i < 4; i++) begin
          av[i] = 16'(v * 16'h3F1 + i * 16'h1111);
          bv[i] = 16'((v * 16'h0A7) ^ 16'hF0F0) + 16'(i);
          set_op(i, 3'(op), av[i], bv[i]);
        end
        @(negedge clk);
        check("R2 alu_vld", 32'(alu_vld), 32'hF);
        check("R8 no viol on alu ops", 32'(viol), 0);
        for (int i = 0; i < 4; i++) begin
          m_res[i] = alu_f(op, av[i], bv[i]);
          check("R2 alu_res", 32'(alu_res[16*i +: 16]), 32'(m_res[i]));
        end
      end
    end
    op_code = '0;
    @(negedge clk);
    check("R2 nop keeps vld low", 32'(alu_vld), 0);
    for (int i = 0; i < 4; i++) check("R2 nop holds result", 32'(alu_res[16*i +: 16]), 32'(m_res[i]));

    // R9 stopped group ignores operations
    run = 1'b0;
    for (int i = 0; i < 4; i++) set_op(i, (i == 0) ? 3'd1 : 3'd5, 16'h7777, 16'h0101);
    repeat (3) begin
      @(negedge clk);
      check("R9 alu_vld", 32'(alu_vld), 0);
      check("R9 viol", 32'(viol), 0);
      check("R9 mul/mem", {mul_vld, mem_vld}, 0);
      for (int i = 0; i < 4; i++) check("R9 result held", 32'(alu_res[16*i +: 16]), 32'(m_res[i]));
    end
    op_code = '0;

    // R3 bypass selects, loaded while stopped
    cfg_load = 1'b1;
    cfg_xbar = (24'd1 << 6) | (24'd6 << 12) | (24'd3 << 21);
    @(negedge clk);
    // R4 load attempt while running must be ignored
    cfg_xbar = '0;
    run = 1'b1;
    for (int c = 0; c < 4; c++) begin
      logic [15:0] e [4];
      for (int i = 0; i < 4; i++) begin
        av[i] = 16'(c * 16'h0123 + i * 16'h0031 + 5);
        bv[i] = 16'(c * 16'h0207 + i * 16'h0013 + 7);
      end
      set_op(0, 3'd1, av[0], bv[0]);
      set_op(1, 3'd1, av[1], bv[1]);
      set_op(2, 3'd1, av[2], bv[2]);
      set_op(3, 3'd4, av[3], bv[3]);
      e[0] = av[0] + bv[0];
      e[1] = m_res[0] + bv[1];
      e[2] = 16'h0000 + bv[2];
      e[3] = av[3] ^ m_res[2];
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        check("R3/R4 bypass result", 32'(alu_res[16*i +: 16]), 32'(e[i]));
        m_res[i] = e[i];
      end
    end
    run = 1'b0; op_code = '0;
    cfg_load = 1'b1; cfg_xbar = '0; cfg_phase = 8'hE4;
    @(negedge clk);
    cfg_load = 1'b0;

    // R5 R6 R8 multiplier rotation: every unit asks every cycle
    for (int k = 0; k < 10; k++) begin
      if (k >= 1 && k - 1 < 8)
        check("R8 viol non-owners", 32'(viol), 32'(4'hF & ~(4'b1 << ((k - 1) % 4))));
      if (k == 9) check("R9 viol after stop", 32'(viol), 0);
      if (k == 1) check("R6 mul not early", 32'(mul_vld), 0);
      if (k >= 2 && k - 2 < 8) begin
        check("R6 mul_vld", 32'(mul_vld), 1);
        check("R6 mul_res", 32'(mul_res), 32'(mexp[k - 2]));
        check("R5 mul_tag owner", 32'(mul_tag), 32'((k - 2) % 4));
      end
      if (k < 8) begin
        run = 1'b1;
        for (int i = 0; i < 4; i++) begin
          av[i] = 16'(k * 37 + i * 11 + 3);
          bv[i] = 16'(k * 53 + i * 7 + 1);
          set_op(i, 3'd5, av[i], bv[i]);
        end
        mexp[k] = 16'(av[k % 4] * bv[k % 4]);
      end else begin
        run = 1'b0; op_code = '0;
      end
      @(negedge clk);
    end
    check("R6 pipeline drained", 32'(mul_vld), 0);

    // R5 R7 R8 memory port with a shared slot and an empty slot
    // slots: unit0=2, unit1=0, unit2=0, unit3=1; phase 3 has no owner
    cfg_load = 1'b1; cfg_phase = 8'h42;
    @(negedge clk);
    cfg_load = 1'b0;
    for (int k = 0; k < 6; k++) begin
      int p;
      run = 1'b1;
      for (int i = 0; i < 4; i++) begin
        av[i] = 16'(16'h0100 + k * 16 + i);
        bv[i] = 16'(16'hA000 + k * 16 + i);
        set_op(i, (i == 0 || i == 3) ? 3'd6 : 3'd7, av[i], bv[i]);
      end
      p = k % 4;
      own = (p == 0) ? 1 : (p == 1) ? 3 : (p == 2) ? 0 : -1;
      @(negedge clk);
      if (own < 0) begin
        check("R5 empty slot no mem", 32'(mem_vld), 0);
        check("R8 all flagged", 32'(viol), 32'hF);
      end else begin
        check("R7 mem_vld", 32'(mem_vld), 1);
        check("R7 mem_tag", 32'(mem_tag), 32'(own));
        check("R7 mem_we", 32'(mem_we), (own == 1 || own == 2) ? 1 : 0);
        check("R7 mem_addr", 32'(mem_addr), 32'(av[own]));
        check("R7 mem_wdata", 32'(mem_wdata), 32'(bv[own]));
        check("R8 viol others", 32'(viol), 32'(4'hF & ~(4'b1 << own)));
      end
    end
    run = 1'b0; op_code = '0;
    @(negedge clk);
    check("R9 mem quiet", 32'(mem_vld), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule